// File: doc/BRIEF.md
# BCD Calendar Timekeeper Core

This block keeps wall-clock time and a calendar as packed BCD counters: seconds, minutes, hours, a day-of-week count, day of month, month and a four-digit year. A base tick enable (`tick_in`), produced elsewhere from the oscillator, is divided by a parameterised prescaler into 128 Hz steps. A 7-bit sub-second counter counts those steps, and each time it wraps the seconds counter advances and the carry ripples up through the calendar in the same clock cycle. Month lengths and the Gregorian leap-year rule are applied.

Software reaches the block through a plain 16-bit write-enable/address/data bus with a register every two bytes. A read of several registers can straddle a counter update. To detect that, software clears the carry flag, reads the registers, and then checks the flag again. It can also use the exposed sub-second count. Two control registers run and stop the clock, reset the prescaler, request a 30-second adjustment, and enable a level carry interrupt.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read as follows: sub-second 0, seconds 0x00, minutes 0x00, hours 0x00, weekday 0x00, day 0x01, month 0x01, year 0x2000. Both control registers read 0 and `carry_irq` is 0.
- R2: The register index is `bus_addr[ADDR_W-1:1]`. Index 0 is sub-second, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day, 6 month, and 7 year (BCD century in bits 15:8, BCD year-of-century in bits 7:0). Index 14 is control 1 and index 15 is control 2. Indices 8 to 13 read 0 and ignore writes. Control 1 reads {carry flag bit 7, carry-interrupt enable bit 4}. Control 2 reads {enable bit 3, adjust-pending bit 2, run bit 0}. All other bits read 0.
- R3: Counting happens only while control 2 bit 0 (run) and bit 3 (enable) are both 1, and only in cycles where `tick_in` is 1. The sub-second counter steps once every PRESC_DIV such ticks. Seconds advance on the PRESC_DIV*128-th tick after a prescaler reset, when the sub-second counter wraps from 127 to 0.
- R4: Seconds go 59 to 00 and carry into minutes. Minutes go 59 to 00 and carry into hours. Hours go 23 to 00 and carry into the day.
- R5: On a day carry the weekday counts 0 to 6 and wraps to 0. The day of month wraps to 01 after the last day of the month and carries into the month. The month wraps 12 to 01 and carries into the year. April, June, September and November have 30 days, February is covered by R6, and the other months have 31.
- R6: February has 29 days in a leap year and 28 otherwise. A year is a leap year when it is divisible by 4, except a century year, which must be divisible by 400.
- R7: The year counts as four BCD digits and wraps from 9999 to 0000.
- R8: Writes to the seconds through year registers take effect only while the run bit is 0. While it is 1 they are ignored. The sub-second register is read-only.
- R9: The carry flag (control 1 bit 7) is set by every seconds update, whether from counting or from an adjustment. Writing 0 to that bit clears the flag, and writing 1 leaves it unchanged. If an update and a clearing write land in the same cycle, the flag ends up set.
- R10: `carry_irq` is 1 exactly while the carry flag and control 1 bit 4 are both 1.
- R11: Writing 1 to control 2 bit 1 clears the prescaler and the sub-second counter at that write. The bit always reads 0.
- R12: Writing 1 to control 2 bit 2 makes an adjustment pending, and the bit reads 1 while it is pending. The adjustment runs at the next `tick_in` cycle with the clock running. Seconds become 00, minutes carry by one if seconds were 30 or more, and the prescaler and sub-second counter clear. The bit then reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | Single-cycle base tick enable feeding the prescaler |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address; register index in bits ADDR_W-1:1 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register, combinational |
| carry_irq | output | 1 | Level interrupt: carry flag and its enable both set |

## Verification
The hardest events to reach are the calendar rollovers: the last day of each month in leap, ordinary, century and 400-year years, and the 9999 year wrap. Counting up to them from the ports would take months of simulated seconds. The bench therefore stops the clock, writes a time one second before each boundary, restarts with a prescaler reset, and waits exactly one second of ticks. It sweeps every month in four year classes, from both the second-to-last and the last day. The deferred adjustment is reached by holding `tick_in` low after the request, so the pending state can be observed before it resolves.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

  typedef struct packed {
    logic       wrap;
    logic [7:0] val;
  } bcd_step_t;

  // one BCD count up, no range limit
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD count with wrap to 'first' once 'last' (or beyond) is reached
  function automatic bcd_step_t bcd_step(input logic [7:0] v,
                                         input logic [7:0] last,
                                         input logic [7:0] first);
    bcd_step_t r;
    if (v >= last) begin
      r.wrap = 1'b1;
      r.val  = first;
    end else begin
      r.wrap = 1'b0;
      r.val  = bcd_inc(v);
    end
    return r;
  endfunction

  // a two-digit BCD value is a multiple of 4 when 2*tens + ones is
  function automatic logic bcd_div4(input logic [7:0] v);
    logic [4:0] s;
    s = {v[7:4], 1'b0} + {1'b0, v[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  // year = {century, year-of-century}, both BCD
  function automatic logic is_leap(input logic [15:0] yr);
    if (yr[7:0] == 8'h00) return bcd_div4(yr[15:8]);
    else                  return bcd_div4(yr[7:0]);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_subsec_div.sv
`timescale 1ns/1ps
module rtc_subsec_div #(
  parameter int PRESC_DIV   = 256,
  parameter int SUBSEC_BITS = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_i,
  input  logic                   tick_i,
  input  logic                   clr_i,
  output logic [SUBSEC_BITS-1:0] sub_o,
  output logic                   sec_tick_o
);
  localparam int PW = (PRESC_DIV > 2) ? $clog2(PRESC_DIV) : 1;

  logic [PW-1:0]          pre_q;
  logic [SUBSEC_BITS-1:0] sub_q;
  logic                   pre_last;
  logic                   step;

  assign pre_last   = (pre_q == PW'(PRESC_DIV - 1));
  assign step       = run_i & tick_i & pre_last;
  assign sec_tick_o = step & (&sub_q) & ~clr_i;
  assign sub_o      = sub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (run_i && tick_i) begin
      pre_q <= pre_last ? '0 : pre_q + PW'(1);
      if (step) sub_q <= sub_q + SUBSEC_BITS'(1);
    end
  end

  // R3
  sub_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(sub_q));

  // R11
  sub_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sub_q == '0));

endmodule

// File: rtl/rtc_clock_chain.sv
`timescale 1ns/1ps
module rtc_clock_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick_i,
  input  logic       adj_i,
  input  logic       we_sec_i,
  input  logic       we_min_i,
  input  logic       we_hour_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       day_carry_o
);
  logic [7:0] sec_q, min_q, hour_q;
  bcd_step_t  sec_s, min_s, hour_s;
  logic       min_inc, hour_inc;

  always_comb begin
    sec_s  = bcd_step(sec_q,  8'h59, 8'h00);
    min_s  = bcd_step(min_q,  8'h59, 8'h00);
    hour_s = bcd_step(hour_q, 8'h23, 8'h00);
  end

  assign min_inc     = (sec_tick_i & sec_s.wrap) | (adj_i & (sec_q >= 8'h30));
  assign hour_inc    = min_inc & min_s.wrap;
  assign day_carry_o = hour_inc & hour_s.wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      if (adj_i)           sec_q <= 8'h00;
      else if (sec_tick_i) sec_q <= sec_s.val;
      else if (we_sec_i)   sec_q <= wdata_i;

      if (min_inc)         min_q <= min_s.val;
      else if (we_min_i)   min_q <= wdata_i;

      if (hour_inc)        hour_q <= hour_s.val;
      else if (we_hour_i)  hour_q <= wdata_i;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;

  // R4
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick_i && !adj_i && sec_q == 8'h59) |=> (sec_q == 8'h00));

  // R4
  min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!min_inc && !we_min_i) |=> $stable(min_q));

  // R12
  adj_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adj_i |=> (sec_q == 8'h00));

endmodule

// File: rtl/rtc_date_chain.sv
`timescale 1ns/1ps
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        day_carry_i,
  input  logic        we_wday_i,
  input  logic        we_day_i,
  input  logic        we_mon_i,
  input  logic        we_year_i,
  input  logic [15:0] wdata_i,
  output logic [7:0]  wday_o,
  output logic [7:0]  day_o,
  output logic [7:0]  mon_o,
  output logic [15:0] year_o
);
  logic [7:0]  wday_q, day_q, mon_q;
  logic [15:0] year_q;
  logic        leap;
  logic [7:0]  last_day;
  bcd_step_t   wday_s, day_s, mon_s, ylo_s;
  logic [7:0]  yhi_next;
  logic        mon_inc, yr_inc;

  always_comb begin
    leap     = is_leap(year_q);
    last_day = month_last(mon_q, leap);
    wday_s   = bcd_step(wday_q, 8'h06, 8'h00);
    day_s    = bcd_step(day_q, last_day, 8'h01);
    mon_s    = bcd_step(mon_q, 8'h12, 8'h01);
    ylo_s    = bcd_step(year_q[7:0], 8'h99, 8'h00);
    yhi_next = (year_q[15:8] >= 8'h99) ? 8'h00 : bcd_inc(year_q[15:8]);
  end

  assign mon_inc = day_carry_i & day_s.wrap;
  assign yr_inc  = mon_inc & mon_s.wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wday_q <= 8'h00;
      day_q  <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 16'h2000;
    end else begin
      if (day_carry_i)    wday_q <= wday_s.val;
      else if (we_wday_i) wday_q <= wdata_i[7:0];

      if (day_carry_i)    day_q <= day_s.val;
      else if (we_day_i)  day_q <= wdata_i[7:0];

      if (mon_inc)        mon_q <= mon_s.val;
      else if (we_mon_i)  mon_q <= wdata_i[7:0];

      if (yr_inc)         year_q <= {ylo_s.wrap ? yhi_next : year_q[15:8], ylo_s.val};
      else if (we_year_i) year_q <= wdata_i;
    end
  end

  assign wday_o = wday_q;
  assign day_o  = day_q;
  assign mon_o  = mon_q;
  assign year_o = year_q;

  // R5
  mon_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_inc && !we_mon_i) |=> $stable(mon_q));

  // R7
  year_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!yr_inc && !we_year_i) |=> $stable(year_q));

  // R5
  day_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mon_inc |=> (day_q == 8'h01));

endmodule

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
module rtc_calendar_core #(
  parameter int PRESC_DIV   = 256,
  parameter int SUBSEC_BITS = 7,
  parameter int ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              carry_irq
);
  localparam int IW = ADDR_W - 1;
  localparam logic [IW-1:0] I_SUB  = IW'(0);
  localparam logic [IW-1:0] I_SEC  = IW'(1);
  localparam logic [IW-1:0] I_MIN  = IW'(2);
  localparam logic [IW-1:0] I_HOUR = IW'(3);
  localparam logic [IW-1:0] I_WDAY = IW'(4);
  localparam logic [IW-1:0] I_DAY  = IW'(5);
  localparam logic [IW-1:0] I_MON  = IW'(6);
  localparam logic [IW-1:0] I_YEAR = IW'(7);
  localparam logic [IW-1:0] I_CTL1 = IW'(14);
  localparam logic [IW-1:0] I_CTL2 = IW'(15);

  logic [IW-1:0] idx;
  logic start_q, en_q, adj_q, cf_q, cie_q;
  logic run, ctl1_we, ctl2_we, cnt_we, presc_rst, adj_go, clr, sec_tick, sec_evt;
  logic day_carry;
  logic [SUBSEC_BITS-1:0] sub_w;
  logic [7:0]  sec_w, min_w, hour_w, wday_w, day_w, mon_w;
  logic [15:0] year_w;

  assign idx       = bus_addr[ADDR_W-1:1];
  assign run       = start_q & en_q;
  assign ctl1_we   = bus_we & (idx == I_CTL1);
  assign ctl2_we   = bus_we & (idx == I_CTL2);
  assign cnt_we    = bus_we & ~start_q;
  assign presc_rst = ctl2_we & bus_wdata[1];
  assign adj_go    = adj_q & run & tick_in;
  assign clr       = presc_rst | adj_go;
  assign sec_evt   = sec_tick | adj_go;

  rtc_subsec_div #(.PRESC_DIV(PRESC_DIV), .SUBSEC_BITS(SUBSEC_BITS)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick_in), .clr_i(clr),
    .sub_o(sub_w), .sec_tick_o(sec_tick)
  );

  rtc_clock_chain u_clock (
    .clk(clk), .rst_n(rst_n), .sec_tick_i(sec_tick), .adj_i(adj_go),
    .we_sec_i(cnt_we & (idx == I_SEC)), .we_min_i(cnt_we & (idx == I_MIN)),
    .we_hour_i(cnt_we & (idx == I_HOUR)), .wdata_i(bus_wdata[7:0]),
    .sec_o(sec_w), .min_o(min_w), .hour_o(hour_w), .day_carry_o(day_carry)
  );

  rtc_date_chain u_date (
    .clk(clk), .rst_n(rst_n), .day_carry_i(day_carry),
    .we_wday_i(cnt_we & (idx == I_WDAY)), .we_day_i(cnt_we & (idx == I_DAY)),
    .we_mon_i(cnt_we & (idx == I_MON)), .we_year_i(cnt_we & (idx == I_YEAR)),
    .wdata_i(bus_wdata),
    .wday_o(wday_w), .day_o(day_w), .mon_o(mon_w), .year_o(year_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      en_q    <= 1'b0;
      adj_q   <= 1'b0;
      cf_q    <= 1'b0;
      cie_q   <= 1'b0;
    end else begin
      if (ctl2_we) begin
        start_q <= bus_wdata[0];
        en_q    <= bus_wdata[3];
        adj_q   <= bus_wdata[2];
      end else if (adj_go) begin
        adj_q   <= 1'b0;
      end
      if (ctl1_we) cie_q <= bus_wdata[4];
      if (sec_evt)                       cf_q <= 1'b1;
      else if (ctl1_we && !bus_wdata[7]) cf_q <= 1'b0;
    end
  end

  assign carry_irq = cf_q & cie_q;

  always_comb begin
    case (idx)
      I_SUB:   bus_rdata = 16'(sub_w);
      I_SEC:   bus_rdata = {8'h00, sec_w};
      I_MIN:   bus_rdata = {8'h00, min_w};
      I_HOUR:  bus_rdata = {8'h00, hour_w};
      I_WDAY:  bus_rdata = {8'h00, wday_w};
      I_DAY:   bus_rdata = {8'h00, day_w};
      I_MON:   bus_rdata = {8'h00, mon_w};
      I_YEAR:  bus_rdata = year_w;
      I_CTL1:  bus_rdata = {8'h00, cf_q, 2'b00, cie_q, 4'h0};
      I_CTL2:  bus_rdata = {8'h00, 4'h0, en_q, adj_q, 1'b0, start_q};
      default: bus_rdata = 16'h0000;
    endcase
  end

  // R9
  cf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> cf_q);

  // R9
  cf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl1_we && bus_wdata[7] && cf_q) |=> cf_q);

  // R9
  cf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cf_q) |-> $past(sec_evt));

  // R8
  run_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && idx == I_SEC && start_q && !tick_in) |=> $stable(sec_w));

  // R12
  adj_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_go && !ctl2_we) |=> !adj_q);

endmodule

// File: tb/rtc_calendar_core_test.sv
`timescale 1ns/1ps
module rtc_calendar_core_test;
  localparam int DIV = 2;
  localparam int SEC_TICKS = DIV * 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        carry_irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  rtc_calendar_core #(.PRESC_DIV(DIV), .SUBSEC_BITS(7), .ADDR_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .carry_irq(carry_irq)
  );

  always #2.5 clk = ~clk;

  localparam logic [4:0] A_SUB = 5'h00, A_SEC = 5'h02, A_MIN = 5'h04, A_HOUR = 5'h06,
                         A_WDAY = 5'h08, A_DAY = 5'h0A, A_MON = 5'h0C, A_YEAR = 5'h0E,
                         A_CTL1 = 5'h1C, A_CTL2 = 5'h1E;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    bus_addr = a;
    #0.1;
    v = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [15:0] yr_bcd(input int y);
    return {to_bcd(y / 100), to_bcd(y % 100)};
  endfunction

  function automatic int mdays(input int m, input int y);
    bit lp;
    lp = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
    case (m)
      2: return lp ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  // stop, write all counters, restart with prescaler reset
  task automatic load_time(input int y, input int mo, input int d, input int w,
                           input int h, input int mi, input int s);
    wr(A_CTL2, 16'h0000);
    wr(A_SEC,  {8'h00, to_bcd(s)});
    wr(A_MIN,  {8'h00, to_bcd(mi)});
    wr(A_HOUR, {8'h00, to_bcd(h)});
    wr(A_WDAY, {8'h00, to_bcd(w)});
    wr(A_DAY,  {8'h00, to_bcd(d)});
    wr(A_MON,  {8'h00, to_bcd(mo)});
    wr(A_YEAR, yr_bcd(y));
    wr(A_CTL2, 16'h000B);
  endtask

  // load, run one second, compare with an arithmetic model
  task automatic one_second(input int y, input int mo, input int d, input int w,
                            input int h, input int mi, input int s);
    string dtag;
    load_time(y, mo, d, w, h, mi, s);
    repeat (SEC_TICKS) @(negedge clk);
    s++;
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h++;
        if (h == 24) begin
          h = 0; w = (w + 1) % 7; d++;
          if (d > mdays(mo, y)) begin
            d = 1; mo++;
            if (mo == 13) begin mo = 1; y = (y + 1) % 10000; end
          end
        end
      end
    end
    dtag = (mo == 2 || mo == 3) ? "R6 day" : "R5 day";
    rdchk("R4 seconds", A_SEC, {8'h00, to_bcd(s)});
    rdchk("R4 minutes", A_MIN, {8'h00, to_bcd(mi)});
    rdchk("R4 hours",   A_HOUR, {8'h00, to_bcd(h)});
    rdchk("R5 weekday", A_WDAY, {8'h00, to_bcd(w)});
    rdchk(dtag,         A_DAY, {8'h00, to_bcd(d)});
    rdchk("R5 month",   A_MON, {8'h00, to_bcd(mo)});
    rdchk("R7 year",    A_YEAR, yr_bcd(y));
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [15:0] v0, v1;
    int yrs [4] = '{2023, 2024, 2100, 2000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdchk("R1 sub", A_SUB, 16'h0000);
    rdchk("R1 sec", A_SEC, 16'h0000);
    rdchk("R1 min", A_MIN, 16'h0000);
    rdchk("R1 hour", A_HOUR, 16'h0000);
    rdchk("R1 wday", A_WDAY, 16'h0000);
    rdchk("R1 day", A_DAY, 16'h0001);
    rdchk("R1 mon", A_MON, 16'h0001);
    rdchk("R1 year", A_YEAR, 16'h2000);
    rdchk("R1 ctl1", A_CTL1, 16'h0000);
    rdchk("R1 ctl2", A_CTL2, 16'h0000);
    chk("R1 irq", 16'(carry_irq), 16'h0000);
    @(negedge clk);

    // R2 reserved slots and unused control bits
    for (int i = 8; i < 14; i++) begin
      wr(5'(i * 2), 16'hA5A5);
      rdchk("R2 reserved", 5'(i * 2), 16'h0000);
      @(negedge clk);
    end
    wr(A_CTL1, 16'hFFFF);
    rdchk("R2 ctl1 bits", A_CTL1, 16'h0010);
    @(negedge clk);
    wr(A_CTL1, 16'h0000);

    // R8 writes while stopped, sub-second read-only
    wr(A_SEC, 16'h0042);
    rdchk("R8 stopped write", A_SEC, 16'h0042);
    @(negedge clk);
    wr(A_SUB, 16'h0055);
    rdchk("R8 sub read-only", A_SUB, 16'h0000);
    @(negedge clk);

    // R3 enable alone or run alone does not count
    tick_in = 1'b1;
    wr(A_CTL2, 16'h0008);
    repeat (600) @(negedge clk);
    rdchk("R3 enable only sec", A_SEC, 16'h0042);
    rdchk("R3 enable only sub", A_SUB, 16'h0000);
    @(negedge clk);
    wr(A_CTL2, 16'h0001);
    repeat (600) @(negedge clk);
    rdchk("R3 run only sec", A_SEC, 16'h0042);
    @(negedge clk);

    // R8 write while running ignored
    wr(A_CTL2, 16'h0009);
    wr(A_SEC, 16'h0011);
    rdchk("R8 running write", A_SEC, 16'h0042);
    @(negedge clk);

    // R3 exact second timing, R9 carry flag, R10 irq
    wr(A_CTL1, 16'h0010);
    load_time(2024, 6, 15, 3, 12, 34, 56);
    repeat (SEC_TICKS - 1) @(negedge clk);
    rdchk("R3 sec before", A_SEC, 16'h0056);
    rdchk("R3 sub at 127", A_SUB, 16'h007F);
    rdchk("R9 flag clear", A_CTL1, 16'h0010);
    chk("R10 irq low", 16'(carry_irq), 16'h0000);
    @(negedge clk);
    rdchk("R3 sec after", A_SEC, 16'h0057);
    rdchk("R3 sub wrapped", A_SUB, 16'h0000);
    rdchk("R9 flag set", A_CTL1, 16'h0090);
    chk("R10 irq high", 16'(carry_irq), 16'h0001);
    @(negedge clk);
    wr(A_CTL1, 16'h0090);
    rdchk("R9 write one keeps", A_CTL1, 16'h0090);
    @(negedge clk);
    wr(A_CTL1, 16'h0010);
    rdchk("R9 write zero clears", A_CTL1, 16'h0010);
    chk("R10 irq cleared", 16'(carry_irq), 16'h0000);
    @(negedge clk);

    // R3 tick gating
    tick_in = 1'b0;
    rd(A_SUB, v0);
    @(negedge clk);
    repeat (300) @(negedge clk);
    rd(A_SUB, v1);
    chk("R3 no tick hold", v1, v0);
    @(negedge clk);
    tick_in = 1'b1;

    // R11 prescaler reset
    load_time(2024, 6, 15, 3, 12, 0, 0);
    repeat (40) @(negedge clk);
    rdchk("R3 sub count", A_SUB, 16'h0014);
    @(negedge clk);
    wr(A_CTL2, 16'h000B);
    rdchk("R11 sub cleared", A_SUB, 16'h0000);
    rdchk("R11 bit reads zero", A_CTL2, 16'h0009);
    @(negedge clk);

    // R12 adjust below 30
    load_time(2024, 6, 15, 3, 8, 10, 29);
    wr(A_CTL2, 16'h000D);
    rdchk("R12 pending", A_CTL2, 16'h000D);
    @(negedge clk);
    rdchk("R12 sec zero", A_SEC, 16'h0000);
    rdchk("R12 min kept", A_MIN, 16'h0010);
    rdchk("R12 done", A_CTL2, 16'h0009);
    rdchk("R12 sub cleared", A_SUB, 16'h0000);
    rdchk("R9 flag by adjust", A_CTL1, 16'h0090);
    @(negedge clk);
    repeat (SEC_TICKS - 2) @(negedge clk);
    rdchk("R12 prescaler restarted", A_SEC, 16'h0000);
    @(negedge clk);
    rdchk("R12 next second", A_SEC, 16'h0001);
    @(negedge clk);

    // R12 adjust at 30 or more, held pending without ticks
    load_time(2024, 6, 15, 3, 9, 59, 45);
    tick_in = 1'b0;
    wr(A_CTL2, 16'h000D);
    repeat (5) @(negedge clk);
    rdchk("R12 waits for tick", A_CTL2, 16'h000D);
    rdchk("R12 sec untouched", A_SEC, 16'h0045);
    @(negedge clk);
    tick_in = 1'b1;
    @(negedge clk);
    rdchk("R12 sec zero 2", A_SEC, 16'h0000);
    rdchk("R12 min carry", A_MIN, 16'h0000);
    rdchk("R12 hour carry", A_HOUR, 16'h0010);
    rdchk("R12 done 2", A_CTL2, 16'h0009);
    @(negedge clk);

    // R4..R7 month-end sweep
    for (int yi = 0; yi < 4; yi++) begin
      for (int m = 1; m <= 12; m++) begin
        int last;
        last = mdays(m, yrs[yi]);
        one_second(yrs[yi], m, last - 1, (m + yi) % 7, 23, 59, 59);
        one_second(yrs[yi], m, last, (m + yi + 1) % 7, 23, 59, 59);
      end
    end
    one_second(2024, 3, 10, 6, 14, 59, 59);
    one_second(1999, 12, 31, 5, 23, 59, 59);
    one_second(9999, 12, 31, 6, 23, 59, 59);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule